// File: doc/BRIEF.md
# Display AUX Native Transaction Engine

This block runs native read and write requests to a display sink across a byte channel that hides the line coding. A caller presents a command, a 16-bit sink address, a transfer length of 1 to 16 bytes and, for writes, the payload. The engine builds the request and streams it to the channel as 32-bit words. It then waits for the channel's completion report and acknowledges that report with a one-cycle clear pulse. Next it pulls the reply words back. The first reply byte is classified as acknowledge, defer or refusal.

When the sink defers, the engine sends the whole request again, up to a fixed number of retries. A read that is acknowledged returns its payload packed most-significant byte first, along with the number of bytes that actually arrived. A failed transaction ends with a status code that tells the failure causes apart.

The word streams are valid/ready. On the transmit side the engine holds `tx_data` and `tx_last` steady while `tx_valid` is high and `tx_ready` is low. On the receive side the channel must hold `rx_data` until it sees `rx_ready`. The command and status pins are plain levels and pulses.

Top module: `aux_xact_engine`

## Requirements
- R1: Request byte 0 is the command in bits 7:4 with bits 3:0 zero (write = 0x8, read = 0x9). Byte 1 is address bits 15:8, byte 2 is address bits 7:0, and byte 3 is the transfer length minus one (`len_m1`).
- R2: A write request is the 4 header bytes followed by `len_m1`+1 payload bytes. A read request is the 4 header bytes only. `tx_size` gives the request byte count, the engine sends exactly ceil(`tx_size`/4) words, and `tx_last` marks the final word.
- R3: Request bytes are packed in order with the first byte of each word in bits 31:24. Write payload byte k is taken from `wr_data` bits [127-8k -: 8]. Unused byte lanes of the final word are zero.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged on the next cycle.
- R5: The reply byte count n is `cpl_size` clamped to `len_m1`+2 for a read and to 1 for a write. The engine consumes ceil(n/4) reply words, unpacked with the first byte in bits 31:24. On acknowledge, `rd_len` = n-1 and reply byte k+1 appears at `rd_data` bits [127-8k -: 8]. Bytes at or beyond `rd_len` are zero, so a short reply is reported with its real length rather than padded.
- R6: The reply code is reply byte 0 ANDed with 0x30. A result of 0x00 means acknowledge (status 0), 0x20 means defer, and any other value is a refusal (status 1). A reply of zero bytes is also a refusal, and no reply words are read for it.
- R7: A defer reply makes the engine resend the whole request. At most 7 resends are made; an 8th defer ends the transaction with status 2 after 8 requests in total.
- R8: Completion flags are checked in a fixed order. Missing done gives status 3, then a receive error gives status 4, then a timeout gives status 5. No reply words are read in any of these cases.
- R9: Each completion report accepted on `cpl_valid` is followed, on the next cycle, by exactly one cycle of `cpl_clear`.
- R10: `busy` rises the cycle after an accepted `start` and stays high until the cycle in which `done` pulses for one cycle with `busy` low. A `start` seen while busy is ignored.
- R11: After reset `busy`, `done`, `tx_valid`, `rx_ready` and `cpl_clear` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (sampled when idle) |
| is_read | input | 1 | 1 = native read, 0 = native write |
| addr | input | 16 | Sink address |
| len_m1 | input | 4 | Transfer length minus one |
| wr_data | input | 128 | Write payload, byte 0 in the top bits |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| status | output | 3 | 0 ok, 1 refused, 2 defer limit, 3 not done, 4 receive error, 5 timeout |
| rd_len | output | 5 | Read payload bytes returned |
| rd_data | output | 128 | Read payload, byte 0 in the top bits |
| tx_valid | output | 1 | Request word valid |
| tx_ready | input | 1 | Channel accepts request word |
| tx_data | output | 32 | Request word |
| tx_last | output | 1 | Final request word |
| tx_size | output | 5 | Request byte count |
| cpl_valid | input | 1 | Completion report strobe |
| cpl_done | input | 1 | Channel finished the exchange |
| cpl_timeout | input | 1 | Sink did not answer |
| cpl_rxerr | input | 1 | Reply was corrupted |
| cpl_size | input | 5 | Reply byte count reported by the channel |
| cpl_clear | output | 1 | Clears done and error flags in the channel |
| rx_valid | input | 1 | Reply word valid |
| rx_ready | output | 1 | Engine takes a reply word |
| rx_data | input | 32 | Reply word |

## Verification
The hardest cases to reach are the boundary of the retry budget and how it combines with the clamped reply count. The channel model therefore counts requests and returns a defer for a programmable number of leading attempts before it gives the final answer. It runs with 3, 7 and 8 leading defers to land on both sides of the limit. The model also reports reply sizes both above and below the caller's buffer, and fills bytes past the reported size with a marker value, so that any over-unpacking shows up in `rd_data`. Transmit back-pressure comes from a fixed stall pattern on `tx_ready`, which makes every request stall partway through.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;
  typedef enum logic [2:0] {
    XS_OK          = 3'd0,
    XS_REFUSED     = 3'd1,
    XS_DEFER_LIMIT = 3'd2,
    XS_NOT_DONE    = 3'd3,
    XS_RX_ERR      = 3'd4,
    XS_TIMEOUT     = 3'd5
  } xact_status_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SEND, SQ_WAIT, SQ_CLR, SQ_RECV, SQ_CHECK
  } seq_state_e;

  localparam logic [3:0] CMD_NATIVE_WR = 4'h8;
  localparam logic [3:0] CMD_NATIVE_RD = 4'h9;
  localparam logic [7:0] REPLY_MASK    = 8'h30;
  localparam logic [7:0] REPLY_ACK     = 8'h00;
  localparam logic [7:0] REPLY_DEFER   = 8'h20;
endpackage

// File: rtl/aux_req_packer.sv
module aux_req_packer
  import aux_xact_pkg::*;
#(
  parameter int MAXLEN = 16,
  parameter int MSGMAX = MAXLEN + 4,
  parameter int LENW   = $clog2(MAXLEN),
  parameter int LW     = $clog2(MSGMAX + 1),
  parameter int IW     = 3
) (
  input  logic                are_read,
  input  logic [15:0]         addr,
  input  logic [LENW-1:0]     len_m1,
  input  logic [8*MAXLEN-1:0] wr_data,
  input  logic [IW-1:0]       widx,
  output logic [31:0]         word,
  output logic [LW-1:0]       msg_size
);
  logic [7:0] msg [MSGMAX];

  assign msg[0] = {(are_read ? CMD_NATIVE_RD : CMD_NATIVE_WR), 4'h0};
  assign msg[1] = addr[15:8];
  assign msg[2] = addr[7:0];
  assign msg[3] = 8'(len_m1);

  for (genvar k = 0; k < MAXLEN; k++) begin : g_pay
    assign msg[4+k] = (!are_read && (LENW'(k) <= len_m1)) ?
                      wr_data[8*(MAXLEN-k)-1 -: 8] : 8'h00;
  end

  always_comb begin
    word = '0;
    for (int b = 0; b < 4; b++) begin
      if (int'(widx) * 4 + b < MSGMAX)
        word[31-8*b -: 8] = msg[int'(widx) * 4 + b];
    end
  end

  assign msg_size = are_read ? LW'(4) : (LW'(len_m1) + LW'(5));
endmodule

// File: rtl/aux_reply_unpacker.sv
module aux_reply_unpacker #(
  parameter int MAXLEN = 16,
  parameter int NW     = 5,
  parameter int LW     = 5,
  parameter int IW     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                we,
  input  logic [IW-1:0]       widx,
  input  logic [31:0]         word,
  input  logic [LW-1:0]       keep_n,
  output logic [7:0]          code,
  output logic [8*MAXLEN-1:0] payload
);
  localparam int NB = 4 * NW;
  logic [7:0] rbuf [NB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) rbuf[i] <= 8'h00;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (clr)
          rbuf[i] <= 8'h00;
        else if (we && (widx == IW'(i / 4)) && (LW'(i) < keep_n))
          rbuf[i] <= word[31-8*(i%4) -: 8];
      end
    end
  end

  assign code = rbuf[0];
  for (genvar k = 0; k < MAXLEN; k++) begin : g_out
    assign payload[8*(MAXLEN-k)-1 -: 8] = rbuf[k+1];
  end
endmodule

// File: rtl/aux_xact_seq.sv
module aux_xact_seq
  import aux_xact_pkg::*;
#(
  parameter int MAXLEN    = 16,
  parameter int DEFER_MAX = 7,
  parameter int LENW      = 4,
  parameter int LW        = 5,
  parameter int IW        = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                is_read,
  input  logic [15:0]         addr,
  input  logic [LENW-1:0]     len_m1,
  input  logic [8*MAXLEN-1:0] wr_data,
  output logic                q_read,
  output logic [15:0]         q_addr,
  output logic [LENW-1:0]     q_len,
  output logic [8*MAXLEN-1:0] q_wdata,
  input  logic [LW-1:0]       msg_size,
  output logic [IW-1:0]       widx,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic                tx_last,
  input  logic                cpl_valid,
  input  logic                cpl_done,
  input  logic                cpl_timeout,
  input  logic                cpl_rxerr,
  input  logic [LW-1:0]       cpl_size,
  output logic                cpl_clear,
  input  logic                rx_valid,
  output logic                rx_ready,
  output logic                buf_clr,
  output logic                buf_we,
  output logic [LW-1:0]       keep_n,
  input  logic [7:0]          reply_code,
  output logic                busy,
  output logic                done,
  output logic [2:0]          status,
  output logic [LW-1:0]       rd_len
);
  localparam int RW = $clog2(DEFER_MAX + 1);

  seq_state_e     state_q;
  logic [IW-1:0]  widx_q;
  logic [RW-1:0]  retry_q;
  logic [LW-1:0]  n_q;
  logic           f_done, f_to, f_rx;
  logic           done_q;
  xact_status_e   status_q;
  logic [LW-1:0]  rd_len_q;
  logic [LW:0]    bufsize, nclamp, tx_words, rx_words;
  logic           rx_last;
  logic [7:0]     code_m;

  always_comb begin
    bufsize  = q_read ? ((LW+1)'(q_len) + (LW+1)'(2)) : (LW+1)'(1);
    nclamp   = ({1'b0, cpl_size} > bufsize) ? bufsize : {1'b0, cpl_size};
    tx_words = ({1'b0, msg_size} + (LW+1)'(3)) >> 2;
    rx_words = ({1'b0, n_q} + (LW+1)'(3)) >> 2;
    rx_last  = ((LW+1)'(widx_q) == rx_words - (LW+1)'(1));
    code_m   = reply_code & REPLY_MASK;
  end

  assign tx_valid  = (state_q == SQ_SEND);
  assign tx_last   = tx_valid && ((LW+1)'(widx_q) == tx_words - (LW+1)'(1));
  assign rx_ready  = (state_q == SQ_RECV);
  assign cpl_clear = (state_q == SQ_CLR);
  assign buf_clr   = (state_q == SQ_CLR);
  assign buf_we    = rx_valid && rx_ready;
  assign keep_n    = n_q;
  assign widx      = widx_q;
  assign busy      = (state_q != SQ_IDLE);
  assign done      = done_q;
  assign status    = status_q;
  assign rd_len    = rd_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      widx_q   <= '0;
      retry_q  <= '0;
      n_q      <= '0;
      f_done   <= 1'b0;
      f_to     <= 1'b0;
      f_rx     <= 1'b0;
      done_q   <= 1'b0;
      status_q <= XS_OK;
      rd_len_q <= '0;
      q_read   <= 1'b0;
      q_addr   <= '0;
      q_len    <= '0;
      q_wdata  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SQ_IDLE: if (start) begin
          q_read  <= is_read;
          q_addr  <= addr;
          q_len   <= len_m1;
          q_wdata <= wr_data;
          retry_q <= '0;
          widx_q  <= '0;
          state_q <= SQ_SEND;
        end
        SQ_SEND: if (tx_ready) begin
          if (tx_last) begin
            widx_q  <= '0;
            state_q <= SQ_WAIT;
          end else begin
            widx_q <= widx_q + 1'b1;
          end
        end
        SQ_WAIT: if (cpl_valid) begin
          f_done  <= cpl_done;
          f_to    <= cpl_timeout;
          f_rx    <= cpl_rxerr;
          n_q     <= nclamp[LW-1:0];
          state_q <= SQ_CLR;
        end
        SQ_CLR: begin
          widx_q <= '0;
          if (!f_done || f_rx || f_to || (n_q == '0)) begin
            state_q  <= SQ_IDLE;
            done_q   <= 1'b1;
            rd_len_q <= '0;
            status_q <= !f_done ? XS_NOT_DONE :
                        f_rx    ? XS_RX_ERR   :
                        f_to    ? XS_TIMEOUT  : XS_REFUSED;
          end else begin
            state_q <= SQ_RECV;
          end
        end
        SQ_RECV: if (rx_valid) begin
          if (rx_last) state_q <= SQ_CHECK;
          else         widx_q  <= widx_q + 1'b1;
        end
        SQ_CHECK: begin
          if (code_m == REPLY_DEFER && retry_q != RW'(DEFER_MAX)) begin
            retry_q <= retry_q + 1'b1;
            widx_q  <= '0;
            state_q <= SQ_SEND;
          end else begin
            state_q  <= SQ_IDLE;
            done_q   <= 1'b1;
            rd_len_q <= (code_m == REPLY_ACK) ? n_q - LW'(1) : '0;
            status_q <= (code_m == REPLY_ACK)   ? XS_OK :
                        (code_m == REPLY_DEFER) ? XS_DEFER_LIMIT : XS_REFUSED;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R10
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid && !rx_ready && !cpl_clear); // R10
  AST_CLEAR_AFTER_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_WAIT && cpl_valid) |=> cpl_clear); // R9
  AST_DEFER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == XS_DEFER_LIMIT) |-> (retry_q == RW'(DEFER_MAX))); // R7
  AST_RESEND_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SEND && $past(state_q) == SQ_CHECK) |-> (retry_q != '0)); // R7
endmodule

// File: rtl/aux_xact_engine.sv
module aux_xact_engine
  import aux_xact_pkg::*;
#(
  parameter int MAXLEN    = 16,
  parameter int DEFER_MAX = 7,
  localparam int MSGMAX   = MAXLEN + 4,
  localparam int NW       = (MSGMAX + 3) / 4,
  localparam int LENW     = $clog2(MAXLEN),
  localparam int LW       = $clog2(MSGMAX + 1),
  localparam int IW       = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                is_read,
  input  logic [15:0]         addr,
  input  logic [LENW-1:0]     len_m1,
  input  logic [8*MAXLEN-1:0] wr_data,
  output logic                busy,
  output logic                done,
  output logic [2:0]          status,
  output logic [LW-1:0]       rd_len,
  output logic [8*MAXLEN-1:0] rd_data,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [31:0]         tx_data,
  output logic                tx_last,
  output logic [LW-1:0]       tx_size,
  input  logic                cpl_valid,
  input  logic                cpl_done,
  input  logic                cpl_timeout,
  input  logic                cpl_rxerr,
  input  logic [LW-1:0]       cpl_size,
  output logic                cpl_clear,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic [31:0]         rx_data
);
  logic                q_read;
  logic [15:0]         q_addr;
  logic [LENW-1:0]     q_len;
  logic [8*MAXLEN-1:0] q_wdata;
  logic [IW-1:0]       widx;
  logic                buf_clr, buf_we;
  logic [LW-1:0]       keep_n;
  logic [7:0]          reply_code;

  aux_xact_seq #(
    .MAXLEN(MAXLEN), .DEFER_MAX(DEFER_MAX), .LENW(LENW), .LW(LW), .IW(IW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read), .addr(addr),
    .len_m1(len_m1), .wr_data(wr_data), .q_read(q_read), .q_addr(q_addr),
    .q_len(q_len), .q_wdata(q_wdata), .msg_size(tx_size), .widx(widx),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
    .cpl_valid(cpl_valid), .cpl_done(cpl_done), .cpl_timeout(cpl_timeout),
    .cpl_rxerr(cpl_rxerr), .cpl_size(cpl_size), .cpl_clear(cpl_clear),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .buf_clr(buf_clr),
    .buf_we(buf_we), .keep_n(keep_n), .reply_code(reply_code),
    .busy(busy), .done(done), .status(status), .rd_len(rd_len)
  );

  aux_req_packer #(
    .MAXLEN(MAXLEN), .MSGMAX(MSGMAX), .LENW(LENW), .LW(LW), .IW(IW)
  ) u_pack (
    .are_read(q_read), .addr(q_addr), .len_m1(q_len), .wr_data(q_wdata),
    .widx(widx), .word(tx_data), .msg_size(tx_size)
  );

  aux_reply_unpacker #(
    .MAXLEN(MAXLEN), .NW(NW), .LW(LW), .IW(IW)
  ) u_unpack (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .widx(widx),
    .word(rx_data), .keep_n(keep_n), .code(reply_code), .payload(rd_data)
  );

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R4
  AST_RDLEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == XS_OK) |-> (rd_len <= LW'(q_len) + LW'(1))); // R5
endmodule

// File: tb/tb_aux_xact_engine.sv
module tb_aux_xact_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, is_read = 1'b0;
  logic [15:0]  addr = '0;
  logic [3:0]   len_m1 = '0;
  logic [127:0] wr_data = '0;
  logic         busy, done;
  logic [2:0]   status;
  logic [4:0]   rd_len;
  logic [127:0] rd_data;
  logic         tx_valid, tx_last;
  logic         tx_ready = 1'b0;
  logic [31:0]  tx_data;
  logic [4:0]   tx_size;
  logic         cpl_valid = 1'b0, cpl_done = 1'b0, cpl_timeout = 1'b0, cpl_rxerr = 1'b0;
  logic [4:0]   cpl_size = '0;
  logic         cpl_clear;
  logic         rx_valid = 1'b0;
  logic         rx_ready;
  logic [31:0]  rx_data = '0;

  aux_xact_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read), .addr(addr),
    .len_m1(len_m1), .wr_data(wr_data), .busy(busy), .done(done),
    .status(status), .rd_len(rd_len), .rd_data(rd_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .tx_size(tx_size), .cpl_valid(cpl_valid), .cpl_done(cpl_done),
    .cpl_timeout(cpl_timeout), .cpl_rxerr(cpl_rxerr), .cpl_size(cpl_size),
    .cpl_clear(cpl_clear), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  // channel model configuration
  int cfg_defer = 0, cfg_size = 0, cfg_seed = 0;
  logic [7:0] cfg_code = 8'h00, cur_code = 8'h00;
  logic cfg_done = 1'b1, cfg_to = 1'b0, cfg_rx = 1'b0;
  // channel model state
  int cyc = 0, attempts = 0, cap_w = 0, cap_words = 0, cpl_wait = 0;
  int rx_idx = 0, rx_cnt = 0, clr_cnt = 0, size_cap = 0;
  logic [7:0] cap [20];

  function automatic logic [7:0] rbyte(int k);
    if (k == 0) return cur_code;
    if (k < cfg_size) return 8'((k * 37 + cfg_seed) & 255);
    return 8'hEE;
  endfunction

  function automatic logic [7:0] wbyte(int k, int seed);
    return 8'((k * 11 + seed * 7 + 3) & 255);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_vec(string req, logic [159:0] act, logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit r;
      cyc++;
      cpl_valid = 1'b0;
      if (cpl_clear) clr_cnt++;
      if (cpl_wait > 0) begin
        cpl_wait--;
        if (cpl_wait == 0) begin
          cur_code    = (attempts <= cfg_defer) ? 8'h20 : cfg_code;
          cpl_valid   = 1'b1;
          cpl_done    = cfg_done;
          cpl_timeout = cfg_to;
          cpl_rxerr   = cfg_rx;
          cpl_size    = 5'(cfg_size);
          rx_idx      = 0;
          rx_cnt      = 0;
        end
      end
      r = (cyc % 3) != 1;
      if (tx_valid && r) begin
        if (cap_w == 0) begin
          attempts++;
          for (int i = 0; i < 20; i++) cap[i] = 8'h00;
        end
        for (int b = 0; b < 4; b++)
          if (cap_w * 4 + b < 20) cap[cap_w * 4 + b] = tx_data[31-8*b -: 8];
        size_cap = int'(tx_size);
        cap_w++;
        if (tx_last) begin
          cap_words = cap_w;
          cap_w = 0;
          cpl_wait = 2;
        end
      end
      tx_ready = r;
      rx_valid = 1'b1;
      rx_data  = {rbyte(4*rx_idx), rbyte(4*rx_idx+1), rbyte(4*rx_idx+2), rbyte(4*rx_idx+3)};
      if (rx_ready) begin
        rx_idx++;
        rx_cnt++;
      end
    end
  end

  task automatic run(bit rd, logic [15:0] a, int lm1, int defer_n, logic [7:0] code,
                     bit f_done, bit f_to, bit f_rx, int size, int exp_status,
                     int exp_att, bit poke, int seed);
    int len, msg, n, waited;
    logic [159:0] exp_msg, act_msg;
    logic [127:0] exp_rd;
    len = lm1 + 1;
    cfg_defer = defer_n; cfg_code = code; cfg_done = f_done; cfg_to = f_to;
    cfg_rx = f_rx; cfg_size = size; cfg_seed = seed;
    attempts = 0; clr_cnt = 0; rx_cnt = 0;
    @(negedge clk);
    is_read = rd; addr = a; len_m1 = 4'(lm1);
    for (int k = 0; k < 16; k++) wr_data[127-8*k -: 8] = wbyte(k, seed);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", int'(busy), 1);
    if (poke) begin
      start = 1'b1; addr = ~a; is_read = ~rd; len_m1 = ~len_m1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    chk("R10 done reached", int'(done), 1);
    chk("R10 busy low at done", int'(busy), 0);
    chk("R6/R7/R8 status", int'(status), exp_status);
    chk("R7 request count", attempts, exp_att);
    chk("R9 clear per completion", clr_cnt, attempts);
    // expected request image
    msg = rd ? 4 : len + 4;
    exp_msg = '0;
    exp_msg[159:152] = rd ? 8'h90 : 8'h80;
    exp_msg[151:144] = a[15:8];
    exp_msg[143:136] = a[7:0];
    exp_msg[135:128] = 8'(lm1);
    if (!rd) for (int k = 0; k < len; k++) exp_msg[127-8*k -: 8] = wbyte(k, seed);
    for (int i = 0; i < 20; i++) act_msg[159-8*i -: 8] = cap[i];
    chk("R1 header byte0", int'(cap[0]), rd ? 8'h90 : 8'h80);
    chk("R1 header length byte", int'(cap[3]), lm1);
    chk_vec("R1/R3 request bytes", act_msg, exp_msg);
    chk("R2 request size", size_cap, msg);
    chk("R2 request words", cap_words, (msg + 3) / 4);
    if (exp_status >= 3 || size == 0) chk("R8 no reply words read", rx_cnt, 0);
    if (exp_status == 0) begin
      n = size < (rd ? len + 1 : 1) ? size : (rd ? len + 1 : 1);
      chk("R5 reply words read", rx_cnt, (n + 3) / 4);
      chk("R5 returned length", int'(rd_len), n - 1);
      exp_rd = '0;
      for (int k = 0; k < n - 1; k++) exp_rd[127-8*k -: 8] = rbyte(k + 1);
      chk_vec("R5 returned payload", {32'h0, rd_data}, {32'h0, exp_rd});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 tx_valid", int'(tx_valid), 0);
    chk("R11 rx_ready", int'(rx_ready), 0);
    chk("R11 cpl_clear", int'(cpl_clear), 0);
    // full-length reads and writes over every length (R1 R2 R3 R5)
    for (int l = 0; l < 16; l++)
      run(1'b1, 16'h0200 + 16'(l * 16'h0111), l, 0, 8'h00, 1, 0, 0, l + 2, 0, 1, 0, l);
    for (int l = 0; l < 16; l++)
      run(1'b0, 16'hA000 ^ 16'(l * 16'h0353), l, 0, 8'h00, 1, 0, 0, 1, 0, 1, 0, l + 40);
    // R5 short reply, oversize reply, write reply clamp
    run(1'b1, 16'h0202, 7, 0, 8'h00, 1, 0, 0, 4, 0, 1, 0, 5);
    run(1'b1, 16'h0010, 1, 0, 8'h00, 1, 0, 0, 20, 0, 1, 0, 6);
    run(1'b0, 16'h0100, 8, 0, 8'h00, 1, 0, 0, 5, 0, 1, 0, 7);
    // R7 defer handling around the limit
    run(1'b1, 16'h0300, 3, 3, 8'h00, 1, 0, 0, 5, 0, 4, 0, 8);
    run(1'b1, 16'h0301, 2, 7, 8'h00, 1, 0, 0, 4, 0, 8, 0, 9);
    run(1'b0, 16'h0302, 2, 8, 8'h00, 1, 0, 0, 1, 2, 8, 0, 10);
    // R6 refusal codes and empty reply
    run(1'b1, 16'h0400, 0, 0, 8'h10, 1, 0, 0, 2, 1, 1, 0, 11);
    run(1'b0, 16'h0401, 0, 0, 8'h30, 1, 0, 0, 1, 1, 1, 0, 12);
    run(1'b1, 16'h0402, 3, 0, 8'hCF, 1, 0, 0, 5, 0, 1, 0, 13);
    run(1'b1, 16'h0403, 3, 0, 8'h00, 1, 0, 0, 0, 1, 1, 0, 14);
    // R8 failure priority
    run(1'b1, 16'h0500, 3, 0, 8'h00, 0, 1, 1, 5, 3, 1, 0, 15);
    run(1'b1, 16'h0501, 3, 0, 8'h00, 1, 1, 1, 5, 4, 1, 0, 16);
    run(1'b0, 16'h0502, 3, 0, 8'h00, 1, 1, 0, 1, 5, 1, 0, 17);
    // R10 start while busy is ignored
    run(1'b1, 16'h0666, 5, 1, 8'h00, 1, 0, 0, 7, 0, 2, 1, 18);
    run(1'b0, 16'h1234, 9, 0, 8'h00, 1, 0, 0, 1, 0, 1, 1, 19);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule